// File: doc/BRIEF.md
# Lane-Partitioned SIMD Adder

This block adds two 128-bit vectors lane by lane. Each instruction picks one of two lane sizes: sixteen 8-bit lanes or eight 16-bit lanes. All lanes are summed in the same cycle. One shared chain of 8-bit segment adders is cut at every lane edge, so no carry reaches a neighbouring lane.

Each instruction also picks its arithmetic:
- **Wrapping** keeps the low bits of the sum.
- **Saturating** clamps an out-of-range lane to the limit of its type.

Each instruction also picks signed (two's-complement) or unsigned lanes. The block drives no carry or overflow flags. Any clamp in an accepted saturating instruction sets a sticky status bit instead. That bit stays set until the host pulses a dedicated clear input.

Top module: `simd_lane_adder`

## Requirements
- R1: With `lane_wide`=0 the operands form sixteen 8-bit lanes; with `lane_wide`=1 they form eight 16-bit lanes. Lane k occupies bits [k*W +: W], where W is the lane width.
- R2: No carry passes between lanes. In 8-bit mode, 0x00FF+0x0001 in a 16-bit field gives 0x0000. In 16-bit mode the same inputs give 0x0100. In 16-bit mode, 0xFFFF+0x0001 gives 0x0000 and leaves the upper lanes untouched.
- R3: With `sat_en`=0 every lane wraps modulo 2^W, so an 8-bit 255+1 gives 0.
- R4: With `sat_en`=1 and `signed_en`=0, a lane whose true sum exceeds 2^W-1 gives all ones, so an 8-bit 250+10 gives 255.
- R5: With `sat_en`=1 and `signed_en`=1, a lane clamps to 2^(W-1)-1 or -2^(W-1): 127/-128 in 8-bit lanes and 32767/-32768 in 16-bit lanes.
- R6: A saturating lane whose sum is in range equals the plain sum. In wrapping mode, `signed_en` does not change the result bits.
- R7: `out_valid` is high exactly one cycle after `in_valid`, and `out_sum` then holds that instruction's result. `out_sum` is unchanged in cycles without `in_valid`.
- R8: `sat_sticky` is set on the edge that accepts a saturating instruction in which any lane clamps.
- R9: `sat_sticky` stays set until `flag_clr` is high on a clock edge. If a new clamp arrives on the same edge as the clear, the bit stays set.
- R10: Wrapping instructions never change `sat_sticky`, even when lanes overflow. Saturating operands presented with `in_valid` low also leave it unchanged.
- R11: After reset, `out_valid`, `out_sum` and `sat_sticky` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Instruction accepted this cycle |
| op_a | input | 128 | First operand vector |
| op_b | input | 128 | Second operand vector |
| lane_wide | input | 1 | 0: sixteen 8-bit lanes, 1: eight 16-bit lanes |
| sat_en | input | 1 | 0: wrap, 1: saturate |
| signed_en | input | 1 | 0: unsigned lanes, 1: two's-complement lanes |
| flag_clr | input | 1 | Clears the sticky saturation bit |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| out_sum | output | 128 | Registered lane-wise sum |
| sat_sticky | output | 1 | Sticky saturation status |

## Verification
Directed vectors put a carry right at a lane edge and apply them in both lane sizes. This shows whether the chain is cut at 8-bit or 16-bit boundaries, or not cut at all.

Overflowing lanes are run in wrap, unsigned-saturate and signed-saturate modes, positive and negative. These separate the modulo result, the all-ones clamp and the two signed limits. They also show which modes are allowed to move the sticky bit.

Clear pulses are placed alone, alongside a clamp, and next to invalid saturating inputs. These fix the set/clear priority.

A long run of random operands with random modes compares each lane against an integer model built on true sums and range limits.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  typedef enum logic {
    LANES_NARROW = 1'b0,
    LANES_WIDE   = 1'b1
  } lane_size_e;

  typedef enum logic {
    ARITH_WRAP = 1'b0,
    ARITH_SAT  = 1'b1
  } arith_mode_e;

  // Two's-complement add overflows when both inputs share a sign
  // and the sum's sign differs from it.
  function automatic logic signed_ovf(input logic a_msb,
                                      input logic b_msb,
                                      input logic s_msb);
    return (a_msb == b_msb) && (s_msb != a_msb);
  endfunction

  // Unsigned add overflows exactly when the lane produced a carry.
  function automatic logic unsigned_ovf(input logic carry);
    return carry;
  endfunction

endpackage

// File: rtl/simd_seg_add.sv
module simd_seg_add #(
  parameter int SEG_W = 8
) (
  input  logic [SEG_W-1:0] a_i,
  input  logic [SEG_W-1:0] b_i,
  input  logic             cin_i,
  output logic [SEG_W-1:0] sum_o,
  output logic             cout_o
);

  logic [SEG_W:0] full;

  always_comb begin
    full   = {1'b0, a_i} + {1'b0, b_i} + {{SEG_W{1'b0}}, cin_i};
    sum_o  = full[SEG_W-1:0];
    cout_o = full[SEG_W];
  end

endmodule

// File: rtl/simd_lane_clamp.sv
module simd_lane_clamp
  import simd_add_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] sum_i,
  input  logic         carry_i,
  input  logic         a_msb_i,
  input  logic         b_msb_i,
  input  logic         sat_i,
  input  logic         sgn_i,
  output logic [W-1:0] res_o,
  output logic         hit_o
);

  localparam logic [W-1:0] UMAX = {W{1'b1}};
  localparam logic [W-1:0] SMAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] SMIN = {1'b1, {(W-1){1'b0}}};

  logic ovf;

  always_comb begin
    ovf   = sgn_i ? signed_ovf(a_msb_i, b_msb_i, sum_i[W-1])
                  : unsigned_ovf(carry_i);
    hit_o = sat_i & ovf;
    if (hit_o) begin
      if (sgn_i) res_o = a_msb_i ? SMIN : SMAX;
      else       res_o = UMAX;
    end else begin
      res_o = sum_i;
    end
  end

endmodule

// File: rtl/simd_sat_status.sv
module simd_sat_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);

  // A set on the clearing edge wins, so no clamp event is lost.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_o <= 1'b0;
    else        flag_o <= (flag_o & ~clr_i) | set_i;
  end

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
#(
  parameter int VEC_W = 128,
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [VEC_W-1:0] op_a,
  input  logic [VEC_W-1:0] op_b,
  input  logic             lane_wide,
  input  logic             sat_en,
  input  logic             signed_en,
  input  logic             flag_clr,
  output logic             out_valid,
  output logic [VEC_W-1:0] out_sum,
  output logic             sat_sticky
);

  localparam int NSEG   = VEC_W / SEG_W;
  localparam int WIDE_W = 2 * SEG_W;
  localparam int NWIDE  = NSEG / 2;

  lane_size_e  lane_sel;
  arith_mode_e arith_sel;

  logic [NSEG-1:0]  seg_cin;
  logic [NSEG-1:0]  seg_cout;
  logic [VEC_W-1:0] raw_sum;
  logic [VEC_W-1:0] narrow_res;
  logic [VEC_W-1:0] wide_res;
  logic [NSEG-1:0]  narrow_hit;
  logic [NWIDE-1:0] wide_hit;
  logic [VEC_W-1:0] sel_res;

  // Named events for the checker
  logic lane_hit_any;
  logic sat_event;

  assign lane_sel  = lane_size_e'(lane_wide);
  assign arith_sel = arith_mode_e'(sat_en);

  // Segmented carry chain: a segment takes its neighbour's carry only
  // when both belong to the same wide lane.
  for (genvar g = 0; g < NSEG; g++) begin : g_seg
    if (g % 2 == 1) begin : g_link
      assign seg_cin[g] = (lane_sel == LANES_WIDE) & seg_cout[g-1];
    end else begin : g_cut
      assign seg_cin[g] = 1'b0;
    end

    simd_seg_add #(.SEG_W(SEG_W)) u_seg (
      .a_i    (op_a[g*SEG_W +: SEG_W]),
      .b_i    (op_b[g*SEG_W +: SEG_W]),
      .cin_i  (seg_cin[g]),
      .sum_o  (raw_sum[g*SEG_W +: SEG_W]),
      .cout_o (seg_cout[g])
    );
  end

  // Clamp bank for narrow lanes
  for (genvar n = 0; n < NSEG; n++) begin : g_nclamp
    simd_lane_clamp #(.W(SEG_W)) u_clamp (
      .sum_i   (raw_sum[n*SEG_W +: SEG_W]),
      .carry_i (seg_cout[n]),
      .a_msb_i (op_a[n*SEG_W + SEG_W - 1]),
      .b_msb_i (op_b[n*SEG_W + SEG_W - 1]),
      .sat_i   (arith_sel == ARITH_SAT),
      .sgn_i   (signed_en),
      .res_o   (narrow_res[n*SEG_W +: SEG_W]),
      .hit_o   (narrow_hit[n])
    );
  end

  // Clamp bank for wide lanes
  for (genvar w = 0; w < NWIDE; w++) begin : g_wclamp
    simd_lane_clamp #(.W(WIDE_W)) u_clamp (
      .sum_i   (raw_sum[w*WIDE_W +: WIDE_W]),
      .carry_i (seg_cout[2*w+1]),
      .a_msb_i (op_a[w*WIDE_W + WIDE_W - 1]),
      .b_msb_i (op_b[w*WIDE_W + WIDE_W - 1]),
      .sat_i   (arith_sel == ARITH_SAT),
      .sgn_i   (signed_en),
      .res_o   (wide_res[w*WIDE_W +: WIDE_W]),
      .hit_o   (wide_hit[w])
    );
  end

  always_comb begin
    if (lane_sel == LANES_WIDE) begin
      sel_res      = wide_res;
      lane_hit_any = |wide_hit;
    end else begin
      sel_res      = narrow_res;
      lane_hit_any = |narrow_hit;
    end
    sat_event = in_valid & lane_hit_any;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_sum   <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_sum <= sel_res;
    end
  end

  simd_sat_status u_status (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (sat_event),
    .clr_i  (flag_clr),
    .flag_o (sat_sticky)
  );

endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
  parameter int VEC_W = 128
) (
  input logic             clk,
  input logic             rst_n,
  input logic             in_valid,
  input logic             sat_en,
  input logic             flag_clr,
  input logic             sat_event,
  input logic             out_valid,
  input logic [VEC_W-1:0] out_sum,
  input logic             sat_sticky
);

  p_valid_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_valid_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_sum));

  p_sticky_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sat_event |=> sat_sticky);

  p_sticky_keep_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !flag_clr) |=> sat_sticky);

  p_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_clr && !sat_event) |=> !sat_sticky);

  p_wrap_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sat_sticky && !(in_valid && sat_en)) |=> !sat_sticky);

endmodule

bind simd_lane_adder simd_lane_adder_chk #(.VEC_W(VEC_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_valid   (in_valid),
  .sat_en     (sat_en),
  .flag_clr   (flag_clr),
  .sat_event  (sat_event),
  .out_valid  (out_valid),
  .out_sum    (out_sum),
  .sat_sticky (sat_sticky)
);

// File: tb/tb_simd_lane_adder.sv
`timescale 1ns/1ps
module tb_simd_lane_adder;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [127:0] op_a = '0;
  logic [127:0] op_b = '0;
  logic         lane_wide = 1'b0;
  logic         sat_en = 1'b0;
  logic         signed_en = 1'b0;
  logic         flag_clr = 1'b0;
  logic         out_valid;
  logic [127:0] out_sum;
  logic         sat_sticky;

  always #2.5 clk = ~clk;

  simd_lane_adder dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .lane_wide(lane_wide), .sat_en(sat_en), .signed_en(signed_en),
    .flag_clr(flag_clr), .out_valid(out_valid), .out_sum(out_sum),
    .sat_sticky(sat_sticky)
  );

  typedef struct {
    logic [127:0] sum;
    string        tag;
  } exp_item_t;

  exp_item_t    sb_q[$];
  int           n_checks = 0;
  int           n_fail = 0;
  logic         mon_on = 1'b0;
  logic         exp_vld = 1'b0;
  logic         exp_sticky = 1'b0;
  string        stk_tag = "R11";
  logic [127:0] last_sum = '0;

  task automatic check(input logic ok, input string tag,
                       input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Integer model: true lane sums compared against the type's range.
  function automatic logic [128:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic wide, input logic sat, input logic sgn);
    int w = wide ? 16 : 8;
    int nl = 128 / w;
    logic hit = 1'b0;
    logic [127:0] r = '0;
    for (int k = 0; k < nl; k++) begin
      longint x = 0, y = 0, s, lo, hi;
      for (int i = 0; i < w; i++) begin
        x[i] = a[k*w+i];
        y[i] = b[k*w+i];
      end
      if (sgn) begin
        if (x >= (longint'(1) << (w-1))) x -= (longint'(1) << w);
        if (y >= (longint'(1) << (w-1))) y -= (longint'(1) << w);
        lo = -(longint'(1) << (w-1));
        hi = (longint'(1) << (w-1)) - 1;
      end else begin
        lo = 0;
        hi = (longint'(1) << w) - 1;
      end
      s = x + y;
      if (sat && s > hi) begin s = hi; hit = 1'b1; end
      else if (sat && s < lo) begin s = lo; hit = 1'b1; end
      for (int i = 0; i < w; i++) r[k*w+i] = s[i];
    end
    return {hit, r};
  endfunction

  // Driver: presents one cycle of stimulus and records what must follow.
  task automatic issue(input logic vld, input logic [127:0] a, input logic [127:0] b,
                       input logic wide, input logic sat, input logic sgn,
                       input logic clr, input string tag);
    logic [128:0] m;
    exp_item_t it;
    @(negedge clk);
    in_valid = vld; op_a = a; op_b = b; lane_wide = wide;
    sat_en = sat; signed_en = sgn; flag_clr = clr;
    m = model(a, b, wide, sat, sgn);
    exp_sticky = (exp_sticky & ~clr) | (vld & m[128]);
    exp_vld = vld;
    stk_tag = tag;
    if (vld) begin
      it.sum = m[127:0];
      it.tag = tag;
      sb_q.push_back(it);
    end
  endtask

  task automatic idle(input string tag);
    issue(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  // Monitor: compares after each edge, away from it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (mon_on) begin
        check(out_valid == exp_vld, "R7 valid", {127'd0, out_valid}, {127'd0, exp_vld});
        if (out_valid) begin
          if (sb_q.size() == 0) begin
            check(1'b0, "R7 unexpected result", out_sum, '0);
          end else begin
            exp_item_t it;
            it = sb_q.pop_front();
            check(out_sum == it.sum, it.tag, out_sum, it.sum);
          end
          last_sum = out_sum;
        end else begin
          check(out_sum == last_sum, "R7 hold", out_sum, last_sum);
        end
        check(sat_sticky == exp_sticky, {stk_tag, " sticky"},
              {127'd0, sat_sticky}, {127'd0, exp_sticky});
      end
    end
  end

  initial begin
    #1000000;
    n_fail++;
    n_checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    logic [127:0] ra, rb;
    repeat (3) @(posedge clk);
    #1;
    check(out_valid == 1'b0, "R11 valid", {127'd0, out_valid}, '0);
    check(out_sum == '0, "R11 sum", out_sum, '0);
    check(sat_sticky == 1'b0, "R11 sticky", {127'd0, sat_sticky}, '0);
    @(negedge clk);
    rst_n = 1'b1;
    mon_on = 1'b1;

    // R3 and R10: wrap in every 8-bit lane, flag untouched
    issue(1'b1, {16{8'hFF}}, {16{8'h01}}, 1'b0, 1'b0, 1'b0, 1'b0, "R3");
    // R1 and R2: the same carry-at-edge operands in both lane sizes
    issue(1'b1, {8{16'h00FF}}, {8{16'h0001}}, 1'b0, 1'b0, 1'b0, 1'b0, "R2 narrow");
    issue(1'b1, {8{16'h00FF}}, {8{16'h0001}}, 1'b1, 1'b0, 1'b0, 1'b0, "R2 wide");
    issue(1'b1, {{7{16'h1234}}, 16'hFFFF}, {{7{16'h0000}}, 16'h0001},
          1'b1, 1'b0, 1'b0, 1'b0, "R2 edge");
    issue(1'b1, 128'h0102_0304_0506_0708_090A_0B0C_0D0E_0F10,
          128'h1010_1010_1010_1010_1010_1010_1010_1010, 1'b0, 1'b0, 1'b0, 1'b0, "R1");
    // R6: signedness does not change wrapping bits; R10 signed overflow in wrap
    issue(1'b1, {16{8'h7F}}, {16{8'h01}}, 1'b0, 1'b0, 1'b1, 1'b0, "R10 wrap signed");
    idle("R10");
    // R10: saturating operands with in_valid low are ignored
    issue(1'b0, {16{8'hFA}}, {16{8'h0A}}, 1'b0, 1'b1, 1'b0, 1'b0, "R10 invalid");
    idle("R10");
    // R6: in-range saturating result equals plain sum, no flag
    issue(1'b1, {16{8'h20}}, {16{8'h30}}, 1'b0, 1'b1, 1'b0, 1'b0, "R6");
    // R4 and R8: unsigned 250+10 clamps in lane 0 only
    issue(1'b1, {{15{8'h01}}, 8'hFA}, {{15{8'h01}}, 8'h0A}, 1'b0, 1'b1, 1'b0, 1'b0, "R4");
    // R9: stays set across a clean instruction
    issue(1'b1, {16{8'h01}}, {16{8'h01}}, 1'b0, 1'b1, 1'b0, 1'b0, "R9 hold");
    idle("R9 hold");
    issue(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 clear");
    idle("R9 clear");
    // R5: signed limits in both widths and both directions
    issue(1'b1, {16{8'h7F}}, {16{8'h01}}, 1'b0, 1'b1, 1'b1, 1'b0, "R5 pos8");
    issue(1'b1, {16{8'h80}}, {16{8'hFF}}, 1'b0, 1'b1, 1'b1, 1'b1, "R5 neg8 R9 set-wins");
    issue(1'b1, {8{16'h7FFF}}, {8{16'h0001}}, 1'b1, 1'b1, 1'b1, 1'b1, "R5 pos16");
    issue(1'b1, {8{16'h8000}}, {8{16'h8000}}, 1'b1, 1'b1, 1'b1, 1'b0, "R5 neg16");
    issue(1'b1, {8{16'hFFFF}}, {8{16'h0002}}, 1'b1, 1'b1, 1'b0, 1'b0, "R4 wide");
    issue(1'b0, '0, '0, 1'b0, 1'b0, 1'b0, 1'b1, "R9 clear");
    // R10: wide unsigned wrap overflow leaves flag clear
    issue(1'b1, {8{16'hFFFF}}, {8{16'h0002}}, 1'b1, 1'b0, 1'b0, 1'b0, "R10 wide");
    idle("R7");

    // Random run across all modes (R1..R10)
    for (int t = 0; t < 400; t++) begin
      ra = {$urandom, $urandom, $urandom, $urandom};
      rb = {$urandom, $urandom, $urandom, $urandom};
      issue(($urandom % 5) != 0, ra, rb, $urandom % 2, $urandom % 2,
            $urandom % 2, ($urandom % 7) == 0, "R1 random");
    end
    idle("R7");
    idle("R7");
    mon_on = 1'b0;
    check(sb_q.size() == 0, "R7 drained", 128'(sb_q.size()), '0);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule